// File: doc/BRIEF.md
# Configuration-Space Indirect Memory Window

This block is one capability structure in a device's configuration space. It gives software a path into a memory region of the device using only configuration reads and writes. Software programs a byte offset and a transfer size into the capability. It then reads or writes a 4-byte data word in the same structure. Each access to that data word turns into one 1-, 2- or 4-byte transaction on a memory-side request/acknowledge port.

The capability is 20 bytes long and occupies five consecutive dwords, starting at dword index `CAP_BASE_DW`:

- dword 0 is a read-only header.
- dword 1 holds a region selector byte. The selector is stored, but it does not change where accesses go.
- dword 2 holds the offset.
- dword 3 holds the size.
- dword 4 is the data word.

The offset comes from untrusted software, so the block aligns it down to a multiple of the size. A size other than 1, 2 or 4 produces no transfer and no error. A configuration access that starts a transfer is not acknowledged until the memory side acknowledges.

Configuration requests are one-cycle pulses on `cfg_req`, with a dword index and byte enables. The requester waits for the one-cycle `cfg_ack` before it issues the next request.

Top module: `cfg_bar_window`

## Requirements
- R1: Header dword bytes are, from byte 0 to byte 3: ID 0x09, next pointer `NEXT_PTR`, structure length 20, type 5. Writes to the header have no effect.
- R2: Byte 0 of dword 1 is a writable selector; bytes 1..3 read as zero. Dwords 2 (offset), 3 (size) and 4 (data) are writable per byte enable, little-endian, with byte b in bits 8b+7..8b.
- R3: After reset, selector, offset, size and data read as zero, and `mem_req` and `cfg_ack` are low.
- R4: The following complete with `cfg_ack` one cycle after the request edge and issue no memory transaction: an access to any dword other than the data dword, an access to the data dword with all byte enables low, and an access outside the capability. Outside the capability, reads return zero and writes change nothing.
- R5: With a size other than 1, 2 or 4, the data dword behaves as a plain register and no memory transaction occurs.
- R6: The memory address is (offset AND NOT(size-1)) truncated to `MEM_AW` bits. The selector value has no influence on it.
- R7: `mem_be` is 0001 for size 1, 0011 for size 2 and 1111 for size 4. Data always travels in the lowest lanes.
- R8: On a configuration write to the data dword, the enabled bytes are merged first. The merged bytes 0..size-1 are then sent with `mem_we`=1.
- R9: On a configuration read of the data dword, a memory read (`mem_we`=0) is issued first. Data bytes 0..size-1 are replaced by the returned lanes, the other bytes are kept, and the configuration read returns the updated dword.
- R10: `mem_req` and its address, enables, direction and write data stay stable until `mem_ack`. `cfg_ack` rises the cycle after `mem_ack` is sampled, and it is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration request pulse |
| cfg_we | input | 1 | 1 = configuration write |
| cfg_dwaddr | input | CFG_DW_AW | Configuration dword index |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_ack | output | 1 | Configuration completion pulse |
| cfg_rdata | output | 32 | Configuration read data, valid with cfg_ack |
| mem_req | output | 1 | Memory-side request, held until mem_ack |
| mem_we | output | 1 | Memory-side direction, 1 = write |
| mem_addr | output | MEM_AW | Memory-side aligned byte address |
| mem_be | output | 4 | Memory-side byte enables |
| mem_wdata | output | 32 | Memory-side write data |
| mem_rdata | input | 32 | Memory-side read data, valid with mem_ack |
| mem_ack | input | 1 | Memory-side completion |

## Verification
A corrupted offset or size register shows up at the memory port. It appears on the very next data-dword access, as a misplaced address or a wrong enable pattern, and it also reads back wrongly one cycle after a configuration read of its dword. A wrong merge or refill of the data word shows up on `mem_wdata` at launch, or in `cfg_rdata` when that same transfer completes. A stuck sequencer shows as a missing or doubled `cfg_ack` within the cycle after `mem_ack`.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam logic [7:0] CAPID_VENDOR   = 8'h09;
  localparam logic [7:0] CAP_KIND_WIN   = 8'h05;
  localparam logic [7:0] CAP_SIZE_BYTES = 8'd20;
  localparam int         CAP_DWORDS     = 5;

  localparam int DW_HDR  = 0;
  localparam int DW_SEL  = 1;
  localparam int DW_OFF  = 2;
  localparam int DW_SIZE = 3;
  localparam int DW_DATA = 4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } win_state_e;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) begin
      m[8*b +: 8] = {8{be[b]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
  parameter int CFG_DW_AW   = 6,
  parameter int CAP_BASE_DW = 16
) (
  input  logic [CFG_DW_AW-1:0]              cfg_dwaddr,
  output logic [cfgwin_pkg::CAP_DWORDS-1:0] dw_hit
);
  import cfgwin_pkg::*;

  for (genvar g = 0; g < CAP_DWORDS; g++) begin : g_hit
    localparam logic [CFG_DW_AW-1:0] IDX = CFG_DW_AW'(CAP_BASE_DW + g);
    assign dw_hit[g] = (cfg_dwaddr == IDX);
  end

endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs #(
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [cfgwin_pkg::CAP_DWORDS-1:0] dw_hit,
  input  logic [3:0]                        wr_be,
  input  logic [31:0]                       wr_data,
  input  logic                              fill_en,
  input  logic [3:0]                        fill_be,
  input  logic [31:0]                       fill_data,
  output logic [31:0]                       win_off,
  output logic [31:0]                       win_size,
  output logic [31:0]                       win_data,
  output logic [31:0]                       rd_word
);
  import cfgwin_pkg::*;

  logic [7:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      win_off  <= '0;
      win_size <= '0;
      win_data <= '0;
    end else begin
      if (wr_en && dw_hit[DW_SEL] && wr_be[0]) begin
        sel_q <= wr_data[7:0];
      end
      for (int b = 0; b < 4; b++) begin
        if (wr_en && dw_hit[DW_OFF] && wr_be[b]) begin
          win_off[8*b +: 8] <= wr_data[8*b +: 8];
        end
        if (wr_en && dw_hit[DW_SIZE] && wr_be[b]) begin
          win_size[8*b +: 8] <= wr_data[8*b +: 8];
        end
        if (fill_en && fill_be[b]) begin
          win_data[8*b +: 8] <= fill_data[8*b +: 8];
        end else if (wr_en && dw_hit[DW_DATA] && wr_be[b]) begin
          win_data[8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (dw_hit[DW_HDR])  rd_word = rd_word | {CAP_KIND_WIN, CAP_SIZE_BYTES, NEXT_PTR, CAPID_VENDOR};
    if (dw_hit[DW_SEL])  rd_word = rd_word | {24'h0, sel_q};
    if (dw_hit[DW_OFF])  rd_word = rd_word | win_off;
    if (dw_hit[DW_SIZE]) rd_word = rd_word | win_size;
    if (dw_hit[DW_DATA]) rd_word = rd_word | win_data;
  end

endmodule

// File: rtl/cfgwin_xfer.sv
module cfgwin_xfer #(
  parameter int MEM_AW = 12
) (
  input  logic [31:0]       win_off,
  input  logic [31:0]       win_size,
  output logic              xfer_ok,
  output logic [MEM_AW-1:0] xfer_addr,
  output logic [3:0]        xfer_be
);
  logic [31:0] align_mask;

  always_comb begin
    xfer_ok    = (win_size == 32'd1) || (win_size == 32'd2) || (win_size == 32'd4);
    align_mask = ~(win_size - 32'd1);
    xfer_addr  = MEM_AW'(win_off & align_mask);
    case (win_size)
      32'd1:   xfer_be = 4'b0001;
      32'd2:   xfer_be = 4'b0011;
      32'd4:   xfer_be = 4'b1111;
      default: xfer_be = 4'b0000;
    endcase
  end

endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl #(
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic              data_hit,
  input  logic              xfer_ok,
  input  logic [MEM_AW-1:0] xfer_addr,
  input  logic [3:0]        xfer_be,
  input  logic [31:0]       merged_wdata,
  input  logic [31:0]       rd_word,
  input  logic [31:0]       win_data,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              cfg_ack,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic              reg_wr_en,
  output logic              fill_en,
  output logic [3:0]        fill_be,
  output logic [31:0]       fill_data
);
  import cfgwin_pkg::*;

  win_state_e  state_q;
  logic        take;
  logic        launch;
  logic        done;
  logic [31:0] refilled;

  always_comb begin
    take      = (state_q == ST_IDLE) && cfg_req;
    launch    = take && data_hit && xfer_ok;
    done      = (state_q == ST_WAIT) && mem_ack;
    reg_wr_en = take && cfg_we;
    fill_en   = done && !mem_we;
    fill_be   = mem_be;
    fill_data = mem_rdata;
    refilled  = (mem_rdata & lane_mask(mem_be)) | (win_data & ~lane_mask(mem_be));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cfg_ack   <= 1'b0;
      cfg_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      cfg_ack <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            mem_req   <= 1'b1;
            mem_we    <= cfg_we;
            mem_addr  <= xfer_addr;
            mem_be    <= xfer_be;
            mem_wdata <= cfg_we ? (merged_wdata & lane_mask(xfer_be)) : 32'h0;
            state_q   <= ST_WAIT;
          end else if (take) begin
            cfg_ack   <= 1'b1;
            cfg_rdata <= cfg_we ? 32'h0 : rd_word;
          end
        end
        ST_WAIT: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cfg_ack   <= 1'b1;
            cfg_rdata <= mem_we ? 32'h0 : refilled;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_bar_window.sv
module cfg_bar_window #(
  parameter int         CFG_DW_AW   = 6,
  parameter int         CAP_BASE_DW = 16,
  parameter logic [7:0] NEXT_PTR    = 8'h00,
  parameter int         MEM_AW      = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_req,
  input  logic                 cfg_we,
  input  logic [CFG_DW_AW-1:0] cfg_dwaddr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic                 cfg_ack,
  output logic [31:0]          cfg_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [MEM_AW-1:0]    mem_addr,
  output logic [3:0]           mem_be,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  input  logic                 mem_ack
);
  import cfgwin_pkg::*;

  logic [CAP_DWORDS-1:0] dw_hit;
  logic [31:0]           win_off;
  logic [31:0]           win_size;
  logic [31:0]           win_data;
  logic [31:0]           rd_word;
  logic [31:0]           merged_wdata;
  logic                  xfer_ok;
  logic [MEM_AW-1:0]     xfer_addr;
  logic [3:0]            xfer_be;
  logic                  reg_wr_en;
  logic                  fill_en;
  logic [3:0]            fill_be;
  logic [31:0]           fill_data;
  logic                  data_hit;

  assign data_hit     = dw_hit[DW_DATA] && (|cfg_be);
  assign merged_wdata = (cfg_wdata & lane_mask(cfg_be)) | (win_data & ~lane_mask(cfg_be));

  cfgwin_decode #(
    .CFG_DW_AW  (CFG_DW_AW),
    .CAP_BASE_DW(CAP_BASE_DW)
  ) u_decode (
    .cfg_dwaddr(cfg_dwaddr),
    .dw_hit    (dw_hit)
  );

  cfgwin_regs #(
    .NEXT_PTR(NEXT_PTR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .dw_hit   (dw_hit),
    .wr_be    (cfg_be),
    .wr_data  (cfg_wdata),
    .fill_en  (fill_en),
    .fill_be  (fill_be),
    .fill_data(fill_data),
    .win_off  (win_off),
    .win_size (win_size),
    .win_data (win_data),
    .rd_word  (rd_word)
  );

  cfgwin_xfer #(
    .MEM_AW(MEM_AW)
  ) u_xfer (
    .win_off  (win_off),
    .win_size (win_size),
    .xfer_ok  (xfer_ok),
    .xfer_addr(xfer_addr),
    .xfer_be  (xfer_be)
  );

  cfgwin_ctrl #(
    .MEM_AW(MEM_AW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .data_hit    (data_hit),
    .xfer_ok     (xfer_ok),
    .xfer_addr   (xfer_addr),
    .xfer_be     (xfer_be),
    .merged_wdata(merged_wdata),
    .rd_word     (rd_word),
    .win_data    (win_data),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .cfg_ack     (cfg_ack),
    .cfg_rdata   (cfg_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .reg_wr_en   (reg_wr_en),
    .fill_en     (fill_en),
    .fill_be     (fill_be),
    .fill_data   (fill_data)
  );

endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
  parameter int MEM_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);  // R10

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_be) &&
                               $stable(mem_we) && $stable(mem_wdata)));  // R10

  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b1111));  // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_be == 4'b1111) ? (mem_addr[1:0] == 2'b00) :
                 (mem_be == 4'b0011) ? (mem_addr[0] == 1'b0) : 1'b1));  // R6

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_ack |=> !cfg_ack);  // R10

  AST_ACK_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (cfg_ack && !mem_req));  // R10

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cfg_ack);  // R10

endmodule

bind cfg_bar_window cfgwin_checker #(.MEM_AW(MEM_AW)) u_cfgwin_checker (
  .clk      (clk),
  .rst      (rst),
  .cfg_ack  (cfg_ack),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack)
);

// File: tb/cfg_bar_window_bench.sv
`timescale 1ns/1ps
module cfg_bar_window_bench;
  localparam int         DWAW = 6;
  localparam int         BASE = 16;
  localparam logic [7:0] NXT  = 8'h5C;
  localparam int         MAW  = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_req = 1'b0;
  logic            cfg_we = 1'b0;
  logic [DWAW-1:0] cfg_dwaddr = '0;
  logic [3:0]      cfg_be = '0;
  logic [31:0]     cfg_wdata = '0;
  logic            cfg_ack;
  logic [31:0]     cfg_rdata;
  logic            mem_req;
  logic            mem_we;
  logic [MAW-1:0]  mem_addr;
  logic [3:0]      mem_be;
  logic [31:0]     mem_wdata;
  logic [31:0]     mem_rdata = '0;
  logic            mem_ack = 1'b0;

  always #2 clk = ~clk;

  cfg_bar_window #(
    .CFG_DW_AW(DWAW), .CAP_BASE_DW(BASE), .NEXT_PTR(NXT), .MEM_AW(MAW)
  ) u_cfg_bar_window (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_dwaddr(cfg_dwaddr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  logic [7:0] bmem [0:4095];
  int          txn_cnt = 0;
  int          ack_cyc = 0;
  int          done_cyc = 0;
  int          lat = 0;
  logic        last_we;
  logic [31:0] last_addr;
  logic [3:0]  last_be;
  logic [31:0] last_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory-side responder with a varying delay
  initial begin
    int wcnt = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (wcnt >= dly) begin
          last_we    = mem_we;
          last_addr  = 32'(mem_addr);
          last_be    = mem_be;
          last_wdata = mem_wdata;
          for (int b = 0; b < 4; b++) begin
            if (mem_we && mem_be[b]) bmem[(int'(mem_addr) + b) % 4096] = mem_wdata[8*b +: 8];
            mem_rdata[8*b +: 8] = bmem[(int'(mem_addr) + b) % 4096];
          end
          mem_ack = 1'b1;
          ack_cyc = ncyc;
          txn_cnt++;
          wcnt = 0;
          dly = (dly + 1) % 3;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic cfg_acc(input logic we, input int dw, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
    int t0;
    int n;
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_dwaddr = DWAW'(dw); cfg_be = be; cfg_wdata = wd;
    t0 = ncyc;
    @(negedge clk);
    cfg_req = 1'b0;
    n = 0;
    while (!cfg_ack && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (!cfg_ack) begin
      checks++; errors++;
      $display("FAIL R10 actual=no_ack expected=ack");
    end
    rd = cfg_rdata;
    done_cyc = ncyc;
    lat = ncyc - t0;
  endtask

  function automatic logic [3:0] be_of(input int sz);
    return (sz == 1) ? 4'b0001 : (sz == 2) ? 4'b0011 : (sz == 4) ? 4'b1111 : 4'b0000;
  endfunction

  function automatic logic [31:0] msk(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  initial begin
    logic [31:0] rd;
    logic [31:0] offs [6];
    int          c0;
    offs[0] = 32'h0; offs[1] = 32'h1; offs[2] = 32'h2; offs[3] = 32'h3;
    offs[4] = 32'h106; offs[5] = 32'h7FFF_FFFB;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'(i * 7 + 3);

    repeat (4) @(negedge clk);
    chk("R3 mem_req", 32'(mem_req), 0);
    chk("R3 cfg_ack", 32'(cfg_ack), 0);
    rst = 1'b0;

    for (int d = 1; d < 5; d++) begin
      cfg_acc(1'b0, BASE + d, 4'hF, 0, rd);
      chk("R3 reset value", rd, 0);
    end
    chk("R3 no txn", txn_cnt, 0);

    cfg_acc(1'b0, BASE, 4'hF, 0, rd);
    chk("R1 header", rd, {8'h05, 8'd20, NXT, 8'h09});
    cfg_acc(1'b1, BASE, 4'hF, 32'hFFFF_FFFF, rd);
    cfg_acc(1'b0, BASE, 4'hF, 0, rd);
    chk("R1 header after write", rd, {8'h05, 8'd20, NXT, 8'h09});

    cfg_acc(1'b1, BASE + 1, 4'hF, 32'hAABB_CC03, rd);
    cfg_acc(1'b0, BASE + 1, 4'hF, 0, rd);
    chk("R2 selector", rd, 32'h0000_0003);
    cfg_acc(1'b1, BASE + 2, 4'b0101, 32'h1122_3344, rd);
    cfg_acc(1'b0, BASE + 2, 4'hF, 0, rd);
    chk("R2 offset byte enables", rd, 32'h0022_0044);

    cfg_acc(1'b1, 3, 4'hF, 32'hDEAD_BEEF, rd);
    chk("R4 outside write latency", lat, 1);
    cfg_acc(1'b0, 3, 4'hF, 0, rd);
    chk("R4 outside read zero", rd, 0);
    chk("R4 outside read latency", lat, 1);
    chk("R4 outside no txn", txn_cnt, 0);

    for (int sz = 0; sz <= 8; sz++) begin
      for (int oi = 0; oi < 6; oi++) begin
        logic [31:0] pat;
        logic [31:0] ea;
        logic [31:0] exp;
        logic [3:0]  ebe;
        bit          ok;
        ok  = (sz == 1 || sz == 2 || sz == 4);
        ebe = be_of(sz);
        ea  = (offs[oi] & ~(32'(sz) - 1)) & 32'hFFF;
        pat = 32'h9E37_0000 ^ 32'(sz << 8) ^ 32'(oi) ^ 32'(oi << 20);
        c0 = txn_cnt;
        cfg_acc(1'b1, BASE + 2, 4'hF, offs[oi], rd);
        cfg_acc(1'b1, BASE + 3, 4'hF, 32'(sz), rd);
        chk("R4 register writes no txn", txn_cnt, c0);
        chk("R4 register write latency", lat, 1);
        cfg_acc(1'b1, BASE + 4, 4'hF, pat, rd);
        if (ok) begin
          chk("R8 write txn count", txn_cnt, c0 + 1);
          chk("R6 write address", last_addr, ea);
          chk("R7 write enables", 32'(last_be), 32'(ebe));
          chk("R8 write direction", 32'(last_we), 1);
          chk("R8 write data", last_wdata & msk(ebe), pat & msk(ebe));
          chk("R10 ack after mem_ack", done_cyc, ack_cyc + 1);
          for (int b = 0; b < 4; b++) bmem[(int'(ea) + b) % 4096] = 8'(oi * 37 + sz * 11 + b + 1);
          exp = pat;
          for (int b = 0; b < sz; b++) exp[8*b +: 8] = 8'(oi * 37 + sz * 11 + b + 1);
          cfg_acc(1'b0, BASE + 4, 4'hF, 0, rd);
          chk("R9 read txn count", txn_cnt, c0 + 2);
          chk("R9 read direction", 32'(last_we), 0);
          chk("R6 read address", last_addr, ea);
          chk("R9 read data", rd, exp);
          cfg_acc(1'b0, BASE + 2, 4'hF, 0, rd);
          chk("R9 data kept", 32'(txn_cnt), 32'(c0 + 2));
        end else begin
          chk("R5 write no txn", txn_cnt, c0);
          cfg_acc(1'b0, BASE + 4, 4'hF, 0, rd);
          chk("R5 plain read", rd, pat);
          chk("R5 read no txn", txn_cnt, c0);
          chk("R5 latency", lat, 1);
        end
      end
    end

    // partial merge with size 4
    cfg_acc(1'b1, BASE + 3, 4'hF, 32'd4, rd);
    cfg_acc(1'b1, BASE + 2, 4'hF, 32'h40, rd);
    cfg_acc(1'b1, BASE + 4, 4'hF, 32'h0102_0304, rd);
    cfg_acc(1'b1, BASE + 4, 4'b0010, 32'hFFFF_AAFF, rd);
    chk("R8 merged write data", last_wdata, 32'h0102_AA04);

    // selector has no influence
    cfg_acc(1'b1, BASE + 1, 4'h1, 32'h5, rd);
    cfg_acc(1'b1, BASE + 2, 4'hF, 32'h20, rd);
    cfg_acc(1'b1, BASE + 4, 4'hF, 32'h5555_6666, rd);
    chk("R6 selector ignored", last_addr, 32'h20);

    // data dword with no byte enables
    c0 = txn_cnt;
    cfg_acc(1'b1, BASE + 4, 4'h0, 32'h7777_7777, rd);
    chk("R4 empty enables no txn", txn_cnt, c0);
    chk("R4 empty enables latency", lat, 1);
    cfg_acc(1'b1, BASE + 3, 4'hF, 32'd0, rd);
    cfg_acc(1'b0, BASE + 4, 4'hF, 0, rd);
    chk("R4 empty enables kept data", rd, 32'h5555_6666);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule